// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

This block is a watchdog peripheral on a simple memory-mapped register port: an address, a write strobe with write data, and read data. A 32-bit down-counter starts from a programmable reload value. Software must write a 16-bit key to the restart address before the count runs out. If it does not, the block records the expiry in a sticky status flag. It can also assert up to three separately enabled outputs for a programmable number of clock cycles: a system reset request, an interrupt, and an external signal.

The count advances either on every bus clock or on rising edges of a slower external tick. The external tick is brought into the bus clock domain by a two-flop synchronizer and an edge detector. When the counter reaches zero it stays there and raises one expiry event. No further event follows until a key write reloads the counter. The status flag is cleared by writing a one to the clear address. If an expiry and a clear land in the same cycle, the expiry wins.

Top module: `wdog_timer`

## Requirements
- R1: After reset the reload register reads 0x03EF1480, the counter reads 0x03EF1480, the pulse length reads 0xFF, and the control and status registers read 0. All three outputs are low.
- R2: Byte offsets are: counter 0x00 (read-only), reload 0x04, restart 0x08, control 0x0C, status 0x10, clear 0x14, pulse length 0x18. Reads of restart, clear and unmapped offsets return 0. Control reads back only bits 4:0 and all other bits read 0.
- R3: Writing exactly 0x00005AB9 to restart copies the reload value into the counter on that clock edge. Any other written value leaves the counter unchanged.
- R4: Control bit 0 enables counting, and the counter then drops by one per count tick. While bit 0 is clear the counter holds its value.
- R5: Once the counter is zero it stays at zero, and the status flag is set on the next clock edge. With the count on the bus clock, enabling at edge W with counter value L sets status after edge W+L+1. Only one expiry occurs per reload.
- R6: Status bit 0 stays set until a write of 1 to bit 0 of the clear address. A clear in the same cycle as an expiry leaves the flag set.
- R7: Control bits 1, 2 and 3 enable the reset, interrupt and external outputs. Each enabled output goes high in the same cycle the status flag is set and stays high for as many cycles as the pulse length register holds. A disabled output stays low.
- R8: A pulse length of 0 produces no output pulse, but the status flag is still set.
- R9: With control bit 4 set, each rising edge of the external tick input decrements the counter once, after a two-flop synchronizer. With bit 4 clear, the tick input has no effect.
- R10: Writes to the status address have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_tick_in | input | 1 | Slow external count source, asynchronous |
| sys_rst_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_sig_o | output | 1 | External signal pulse |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data follows the address within the same cycle. With counting on the bus clock, a counter loaded with L and enabled at edge W reaches zero at edge W+L. Status and the outputs change at edge W+L+1, and the outputs fall len cycles later. The bench drives every input just after a rising edge and reads the design between edges. It counts edges from the enabling write, sweeps reload values 0 to 5 against pulse lengths 0 to 3, and lands a clear write on exactly the expiry edge. The external tick path is checked by counter value after settling, because its latency through the synchronizer is three bus cycles.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the watchdog timer.
// Assumes byte offsets that fit in a 5-bit address.
package wdog_pkg;

    // Register offsets
    localparam int OFS_COUNT   = 'h00;
    localparam int OFS_RELOAD  = 'h04;
    localparam int OFS_RESTART = 'h08;
    localparam int OFS_CTRL    = 'h0C;
    localparam int OFS_STATUS  = 'h10;
    localparam int OFS_CLEAR   = 'h14;
    localparam int OFS_PLEN    = 'h18;

    // Restart key and reset values
    localparam logic [31:0] KICK_KEY     = 32'h0000_5AB9;
    localparam logic [31:0] RELOAD_RESET = 32'h03EF_1480;
    localparam logic [7:0]  PLEN_RESET   = 8'hFF;

    // Number of pulse outputs (reset, interrupt, external)
    localparam int NUM_PULSE = 3;

    // Control register layout, bit 4 down to bit 0
    typedef struct packed {
        logic tick_sel;   // bit 4: 1 = external tick, 0 = bus clock
        logic ext_en;     // bit 3
        logic irq_en;     // bit 2
        logic rst_en;     // bit 1
        logic run;        // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_tick_sync.sv
`timescale 1ns/1ps
// Module: wdog_tick_sync
// Synchronizes a slow asynchronous tick into the bus clock domain and emits
// a one-cycle pulse per rising edge. Assumes the tick period exceeds two bus
// clock periods, so no edge is lost.
module wdog_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_rise
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Purpose: shift the async input through the synchronizer and history flop
    generate
        for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= tick_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Purpose: rising edge of the synchronized level
    assign tick_rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
// Module: wdog_counter
// Down-counter with key reload. It stops at zero and raises exactly one
// expiry event per reload. Assumes restart_hit is a one-cycle strobe.
// A restart in the expiry cycle reloads and suppresses that expiry.
module wdog_counter #(
    parameter int          CNT_W     = 32,
    parameter logic [31:0] CNT_RESET = 32'h03EF_1480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart_hit,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire_evt
);

    logic armed_q;
    logic at_zero;
    logic step;

    assign at_zero    = (cnt_q == '0);
    assign step       = run && tick && !at_zero;
    assign expire_evt = armed_q && run && at_zero && !restart_hit;

    // Purpose: counter value and one-shot arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= CNT_W'(CNT_RESET);
            armed_q <= 1'b1;
        end else if (restart_hit) begin
            cnt_q   <= reload;
            armed_q <= 1'b1;
        end else begin
            if (step)       cnt_q   <= cnt_q - 1'b1;
            if (expire_evt) armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
// Module: wdog_pulse
// Shared length counter that opens a window of len cycles after each
// expiry event, gated per output by its enable bit. Assumes a length of
// zero means no window at all.
module wdog_pulse #(
    parameter int LEN_W   = 8,
    parameter int NUM_OUT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire_evt,
    input  logic [LEN_W-1:0]   len,
    input  logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] pulse_o,
    output logic               active
);

    logic [LEN_W-1:0] left_q;

    // Purpose: load the window length on expiry, then count it down
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (expire_evt)     left_q <= len;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign active = (left_q != '0);

    // Purpose: gate each output by its own enable
    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
            assign pulse_o[g] = active & out_en[g];
        end
    endgenerate

endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
// Module: wdog_regs
// Register file: reload, control, pulse length, sticky status, write-only
// strobes for restart and clear, and the read mux. Assumes single-cycle
// write strobes and full-offset decode.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              expire_evt,
    output logic [DATA_W-1:0] reload_q,
    output ctrl_t             ctrl_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              status_q,
    output logic              restart_hit,
    output logic              clear_hit
);

    logic sel_reload, sel_restart, sel_ctrl, sel_clear, sel_plen;

    // Purpose: write decode per offset
    assign sel_reload  = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
    assign sel_restart = bus_wr && (bus_addr == ADDR_W'(OFS_RESTART));
    assign sel_ctrl    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_clear   = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
    assign sel_plen    = bus_wr && (bus_addr == ADDR_W'(OFS_PLEN));

    assign restart_hit = sel_restart && (bus_wdata == DATA_W'(KICK_KEY));
    assign clear_hit   = sel_clear && bus_wdata[0];

    // Purpose: programmable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= DATA_W'(RELOAD_RESET);
            ctrl_q   <= '0;
            len_q    <= LEN_W'(PLEN_RESET);
        end else begin
            if (sel_reload) reload_q <= bus_wdata;
            if (sel_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (sel_plen)   len_q    <= bus_wdata[LEN_W-1:0];
        end
    end

    // Purpose: sticky expiry flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (expire_evt) status_q <= 1'b1;
        else if (clear_hit)  status_q <= 1'b0;
    end

    // Purpose: read mux, write-only and unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_COUNT):  bus_rdata = cnt_val;
            ADDR_W'(OFS_RELOAD): bus_rdata = reload_q;
            ADDR_W'(OFS_CTRL):   bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_STATUS): bus_rdata = DATA_W'(status_q);
            ADDR_W'(OFS_PLEN):   bus_rdata = DATA_W'(len_q);
            default:             bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
// Module: wdog_timer (top)
// Watchdog timer with a register port, key-protected restart, a sticky
// expiry flag and three gated pulse outputs. Assumes a synchronous
// active-low reset and an external tick slower than half the bus clock.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick_in,
    output logic              sys_rst_o,
    output logic              irq_o,
    output logic              ext_sig_o
);

    logic [DATA_W-1:0]    reload_q;
    logic [DATA_W-1:0]    cnt_q;
    ctrl_t                ctrl_q;
    logic [LEN_W-1:0]     len_q;
    logic                 status_q;
    logic                 restart_hit;
    logic                 clear_hit;
    logic                 expire_evt;
    logic                 ext_rise;
    logic                 tick;
    logic                 pulse_active;
    logic [NUM_PULSE-1:0] out_en;
    logic [NUM_PULSE-1:0] pulses;

    wdog_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_val     (cnt_q),
        .expire_evt  (expire_evt),
        .reload_q    (reload_q),
        .ctrl_q      (ctrl_q),
        .len_q       (len_q),
        .status_q    (status_q),
        .restart_hit (restart_hit),
        .clear_hit   (clear_hit)
    );

    wdog_tick_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (ext_tick_in),
        .tick_rise  (ext_rise)
    );

    // Purpose: count source select
    assign tick = ctrl_q.tick_sel ? ext_rise : 1'b1;

    wdog_counter #(
        .CNT_W     (DATA_W),
        .CNT_RESET (RELOAD_RESET)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctrl_q.run),
        .tick        (tick),
        .restart_hit (restart_hit),
        .reload      (reload_q),
        .cnt_q       (cnt_q),
        .expire_evt  (expire_evt)
    );

    // Purpose: output enables in reset, interrupt, external order
    assign out_en = {ctrl_q.ext_en, ctrl_q.irq_en, ctrl_q.rst_en};

    wdog_pulse #(
        .LEN_W   (LEN_W),
        .NUM_OUT (NUM_PULSE)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_evt (expire_evt),
        .len        (len_q),
        .out_en     (out_en),
        .pulse_o    (pulses),
        .active     (pulse_active)
    );

    assign sys_rst_o = pulses[0];
    assign irq_o     = pulses[1];
    assign ext_sig_o = pulses[2];

endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
// Module: wdog_timer_chk
// Checker bound to wdog_timer. It watches the counter, the status flag and
// the pulse window against the register strobes.
module wdog_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             status,
    input logic             clear_hit,
    input logic             restart_hit,
    input logic             run,
    input logic             tick,
    input logic             pulse_active
);

    AST_KEY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_hit |=> cnt == $past(reload));  // R3

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart_hit) |=> $stable(cnt));  // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt != '0 && !restart_hit) |=> cnt == $past(cnt) - 1'b1);  // R4

    AST_STAYS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !restart_hit) |=> cnt == '0);  // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clear_hit) |=> status);  // R6

    AST_PULSE_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |-> status);  // R7

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt          (cnt_q),
    .reload       (reload_q),
    .status       (status_q),
    .clear_hit    (clear_hit),
    .restart_hit  (restart_hit),
    .run          (ctrl_q.run),
    .tick         (tick),
    .pulse_active (pulse_active)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
// Bench for wdog_timer: sweeps reload and pulse length and computes the
// expected expiry cycle and pulse width arithmetically.
module wdog_timer_tb;

    localparam logic [4:0] A_CNT = 5'h00, A_REL = 5'h04, A_KICK = 5'h08,
                           A_CTRL = 5'h0C, A_STAT = 5'h10, A_CLR = 5'h14,
                           A_LEN = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick_in = 1'b0;
    logic        sys_rst_o, irq_o, ext_sig_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    wdog_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_tick_in (ext_tick_in),
        .sys_rst_o   (sys_rst_o),
        .irq_o       (irq_o),
        .ext_sig_o   (ext_sig_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Drives one write; called just after a rising edge, returns just after the next
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    // Combinational read between edges
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick_in = 1'b1;
            cycles(3);
            ext_tick_in = 1'b0;
            cycles(3);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        int k, w;
        logic mismatch;

        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset values
        rd(A_REL, v);  check("R1 reload", v, 32'h03EF1480);
        rd(A_CNT, v);  check("R1 counter", v, 32'h03EF1480);
        rd(A_LEN, v);  check("R1 length", v, 32'h000000FF);
        rd(A_CTRL, v); check("R1 control", v, 32'h0);
        rd(A_STAT, v); check("R1 status", v, 32'h0);
        check("R1 outputs", {29'b0, sys_rst_o, irq_o, ext_sig_o}, 32'h0);

        // R2 write-only and unused bits
        wr(A_KICK, 32'h1234);
        rd(A_KICK, v); check("R2 restart reads 0", v, 32'h0);
        rd(A_CLR, v);  check("R2 clear reads 0", v, 32'h0);
        rd(5'h1C, v);  check("R2 unmapped reads 0", v, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R2 control width", v, 32'h1F);
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h1);

        // R4 count and hold
        wr(A_REL, 32'd20);
        wr(A_KICK, 32'h5AB9);
        rd(A_CNT, v);  check("R3 key loads", v, 32'd20);
        wr(A_CTRL, 32'h1);
        cycles(3);
        rd(A_CNT, v);  check("R4 count down", v, 32'd17);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v);  check("R4 last step", v, 32'd16);
        cycles(5);
        rd(A_CNT, v);  check("R4 hold when off", v, 32'd16);

        // R3 wrong keys
        wr(A_REL, 32'h1234);
        wr(A_KICK, 32'h5AB8);
        rd(A_CNT, v);  check("R3 wrong key", v, 32'd16);
        wr(A_KICK, 32'h0001_5AB9);
        rd(A_CNT, v);  check("R3 wide key", v, 32'd16);
        wr(A_KICK, 32'h5AB9);
        rd(A_CNT, v);  check("R3 exact key", v, 32'h1234);

        // R10 status write ignored
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); check("R10 status write", v, 32'h0);

        // R5 R7 R8 sweep over reload and pulse length
        for (int L = 0; L <= 5; L++) begin
            for (int len = 0; len <= 3; len++) begin
                wr(A_CTRL, 32'h0);
                wr(A_CLR, 32'h1);
                wr(A_REL, L);
                wr(A_LEN, len);
                wr(A_KICK, 32'h5AB9);
                wr(A_CTRL, 32'h0F);
                k = 0;
                rd(A_STAT, v);
                while (v[0] == 1'b0 && k < 100) begin
                    cycles(1);
                    k++;
                    rd(A_STAT, v);
                end
                check($sformatf("R5 expiry edge L=%0d", L), k, L + 1);
                rd(A_CNT, v);
                check("R5 counter at zero", v, 32'h0);
                w = 0;
                mismatch = 1'b0;
                while (irq_o && w < 300) begin
                    if (sys_rst_o !== irq_o || ext_sig_o !== irq_o) mismatch = 1'b1;
                    cycles(1);
                    w++;
                end
                check($sformatf("R7 R8 width len=%0d", len), w, len);
                check("R7 outputs together", {31'b0, mismatch}, 32'h0);
                wr(A_CLR, 32'h1);
                cycles(6);
                rd(A_STAT, v);
                check("R5 single expiry", v, 32'h0);
                check("R8 outputs idle", {29'b0, sys_rst_o, irq_o, ext_sig_o}, 32'h0);
            end
        end

        // R6 set wins over simultaneous clear; R7 per-output enable
        wr(A_CTRL, 32'h0);
        wr(A_REL, 32'd4);
        wr(A_LEN, 32'd5);
        wr(A_KICK, 32'h5AB9);
        wr(A_CTRL, 32'h05);
        cycles(4);
        wr(A_CLR, 32'h1);
        rd(A_STAT, v); check("R6 set beats clear", v, 32'h1);
        check("R7 irq only", {29'b0, sys_rst_o, irq_o, ext_sig_o}, 32'b010);
        cycles(2);
        rd(A_STAT, v); check("R6 sticky", v, 32'h1);
        wr(A_CLR, 32'h2);
        rd(A_STAT, v); check("R6 bit0 needed", v, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_STAT, v); check("R6 clear", v, 32'h0);

        // R9 external tick source
        wr(A_CTRL, 32'h0);
        wr(A_REL, 32'd10);
        wr(A_KICK, 32'h5AB9);
        wr(A_CTRL, 32'h11);
        cycles(5);
        rd(A_CNT, v);  check("R9 no tick no step", v, 32'd10);
        ext_pulses(4);
        cycles(5);
        rd(A_CNT, v);  check("R9 four ticks", v, 32'd6);
        wr(A_CTRL, 32'h10);
        ext_pulses(2);
        cycles(5);
        rd(A_CNT, v);  check("R9 ticks while off", v, 32'd6);
        wr(A_CTRL, 32'h01);
        cycles(3);
        wr(A_CTRL, 32'h00);
        ext_pulses(2);
        rd(A_CNT, v);  check("R9 bus clock select ignores tick", v, 32'd2);

        summary();
    end

endmodule